// File: doc/BRIEF.md
# SMBus Host Controller Register File

This block is the software-facing register set of an SMBus host controller. A processor reaches it through a byte-wide register port with eight offsets. It programs a target address, a command byte and up to two data bytes, then writes the control register with the start bit set. The block checks the requested protocol. For a supported protocol it raises a request to a downstream transaction engine, which drives the serial wires. For an unsupported protocol it records an error and issues nothing.

When the engine reports completion, the block clears busy, sets done and captures any read result into the data registers. A 32-entry block buffer is shared between the host and the engine. The host reaches it one byte at a time through a single port whose index advances on every access. The engine reaches it through a direct index.

Top module: `smb_host_regs`

## Requirements
- R1: A write to control (offset 2) with bit 6 set, while no transfer is pending and with protocol field bits 4:2 equal to 0, 1, 2, 3 or 5, raises `xfer_req` on the next cycle. At the same time `xfer_proto` carries that field, `xfer_read` carries address register bit 0 (1 = read), `xfer_slave` carries address bits 7:1, and `xfer_cmd`, `xfer_d0` and `xfer_d1` carry the command, data0 and data1 registers.
- R2: `xfer_req` stays high until a cycle with `xfer_done` high. On the next cycle, status bit 0 (busy) reads 0 and status bit 1 (done) reads 1. A start written while busy is ignored, and the latched protocol does not change.
- R3: On completion of a read (address bit 0 = 1), data0 takes `xfer_rx0` for protocols 1, 2 and 5 (for protocol 5 this is the byte count). For protocol 3, data0 takes `xfer_rx0` and data1 takes `xfer_rx1`. Protocol 0 and all write transfers leave data0 and data1 unchanged.
- R4: A start with protocol 4, 6 or 7 sets status bit 2 (error) on the next cycle and does not raise `xfer_req`.
- R5: Any write to status (offset 0) clears the done and error bits and sets the block index to 0.
- R6: Each host read or write of the block port (offset 7) accesses buffer[index], then advances the index, wrapping from 31 to 0.
- R7: A read of control returns only its bits 4:0, with bits 7:5 as 0, and sets the block index to 0.
- R8: Offsets 3, 4, 5 and 6 read back the command, address, data0 and data1 registers. Offset 1 reads 0. Status reads {5'b0, error, done, busy}.
- R9: The engine reads buffer[`blk_eng_idx`] combinationally on `blk_eng_rdata`. It writes that entry when `blk_eng_we` is high.
- R10: After reset all registers and status read 0, the block index is 0 and `xfer_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects occur at the clock edge) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| xfer_req | output | 1 | Transfer pending toward the engine |
| xfer_proto | output | 3 | Protocol latched at start |
| xfer_read | output | 1 | Direction: 1 = read |
| xfer_slave | output | 7 | Target address |
| xfer_cmd | output | 8 | Command byte |
| xfer_d0 | output | 8 | Data0 (low byte or block count) |
| xfer_d1 | output | 8 | Data1 (high byte) |
| xfer_done | input | 1 | Engine completion pulse |
| xfer_rx0 | input | 8 | Received low byte or block count |
| xfer_rx1 | input | 8 | Received high byte |
| blk_eng_idx | input | 5 | Engine buffer index |
| blk_eng_rdata | output | 8 | Buffer entry at `blk_eng_idx` |
| blk_eng_we | input | 1 | Engine buffer write enable |
| blk_eng_wdata | input | 8 | Engine buffer write data |

## Verification
The embedded properties check the following on every cycle:
- a pending request holds until completion;
- completion turns busy into done;
- a bad protocol code yields the error flag with no request;
- a status write clears the flags and the index;
- the block index steps and wraps by one per port access;
- a control read zeroes the index.

Only the bench scenarios can show the rest:
- the values seen through the port, such as read results landing in the right data register for each protocol;
- write transfers leaving the data registers untouched;
- a 33-byte write overwriting entry 0;
- the engine and the host seeing the same buffer contents.

// File: rtl/smb_host_regs.sv
module smb_host_regs #(
  parameter int BLK_DEPTH = 32,
  parameter int DW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [2:0]                   bus_addr,
  input  logic [DW-1:0]                bus_wdata,
  output logic [DW-1:0]                bus_rdata,
  output logic                         xfer_req,
  output logic [2:0]                   xfer_proto,
  output logic                         xfer_read,
  output logic [6:0]                   xfer_slave,
  output logic [DW-1:0]                xfer_cmd,
  output logic [DW-1:0]                xfer_d0,
  output logic [DW-1:0]                xfer_d1,
  input  logic                         xfer_done,
  input  logic [DW-1:0]                xfer_rx0,
  input  logic [DW-1:0]                xfer_rx1,
  input  logic [$clog2(BLK_DEPTH)-1:0] blk_eng_idx,
  output logic [DW-1:0]                blk_eng_rdata,
  input  logic                         blk_eng_we,
  input  logic [DW-1:0]                blk_eng_wdata
);
  localparam int IW = $clog2(BLK_DEPTH);
  localparam logic [IW-1:0] LAST = IW'(BLK_DEPTH - 1);
  localparam logic [2:0] OFF_STAT = 3'd0, OFF_CTL = 3'd2, OFF_CMD = 3'd3,
                         OFF_ADR = 3'd4, OFF_D0 = 3'd5, OFF_D1 = 3'd6, OFF_BLK = 3'd7;

  logic [DW-1:0] ctl_q, cmd_q, adr_q, d0_q, d1_q;
  logic [DW-1:0] blk_mem [BLK_DEPTH];
  logic [IW-1:0] idx_q;
  logic [2:0]    pr_q;
  logic          busy_q, done_q, err_q;

  function automatic logic proto_ok(input logic [2:0] p);
    return (p <= 3'd3) || (p == 3'd5);
  endfunction

  wire wr_stat  = bus_wr && bus_addr == OFF_STAT;
  wire wr_ctl   = bus_wr && bus_addr == OFF_CTL;
  wire rd_ctl   = bus_rd && bus_addr == OFF_CTL;
  wire blk_acc  = (bus_wr || bus_rd) && bus_addr == OFF_BLK;
  wire start    = wr_ctl && bus_wdata[6] && !busy_q;
  wire go       = start && proto_ok(bus_wdata[4:2]);
  wire bad      = start && !proto_ok(bus_wdata[4:2]);
  wire finish   = busy_q && xfer_done;

  assign xfer_req      = busy_q;
  assign xfer_proto    = pr_q;
  assign xfer_read     = adr_q[0];
  assign xfer_slave    = adr_q[7:1];
  assign xfer_cmd      = cmd_q;
  assign xfer_d0       = d0_q;
  assign xfer_d1       = d1_q;
  assign blk_eng_rdata = blk_mem[blk_eng_idx];

  always_comb begin
    case (bus_addr)
      OFF_STAT: bus_rdata = {{(DW-3){1'b0}}, err_q, done_q, busy_q};
      OFF_CTL:  bus_rdata = {{(DW-5){1'b0}}, ctl_q[4:0]};
      OFF_CMD:  bus_rdata = cmd_q;
      OFF_ADR:  bus_rdata = adr_q;
      OFF_D0:   bus_rdata = d0_q;
      OFF_D1:   bus_rdata = d1_q;
      OFF_BLK:  bus_rdata = blk_mem[idx_q];
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0; cmd_q <= '0; adr_q <= '0; d0_q <= '0; d1_q <= '0;
      idx_q <= '0; pr_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata;
      if (bus_wr && bus_addr == OFF_CMD) cmd_q <= bus_wdata;
      if (bus_wr && bus_addr == OFF_ADR) adr_q <= bus_wdata;
      if (bus_wr && bus_addr == OFF_D1)  d1_q  <= bus_wdata;
      if (bus_wr && bus_addr == OFF_D0)  d0_q  <= bus_wdata;

      if (wr_stat || rd_ctl)  idx_q <= '0;
      else if (blk_acc)       idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;

      if (wr_stat) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (bad) err_q <= 1'b1;
      if (go) begin
        busy_q <= 1'b1;
        pr_q   <= bus_wdata[4:2];
      end
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (adr_q[0]) begin
          case (pr_q)
            3'd1, 3'd2, 3'd5: d0_q <= xfer_rx0;
            3'd3: begin d0_q <= xfer_rx0; d1_q <= xfer_rx1; end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wr && bus_addr == OFF_BLK) blk_mem[idx_q] <= bus_wdata;
    else if (blk_eng_we)               blk_mem[blk_eng_idx] <= blk_eng_wdata;
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> xfer_req);
  // R2
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_done && !bus_wr) |=> (!xfer_req && done_q));
  // R4
  bad_proto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_req && wr_ctl && bus_wdata[6] && (bus_wdata[4:2] == 3'd4 || bus_wdata[4:2] >= 3'd6))
    |=> (!xfer_req && err_q));
  // R5
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_rd && !(xfer_req && xfer_done)) |=> (!done_q && !err_q && idx_q == '0));
  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_acc && !(bus_wr && bus_rd)) |=>
      (idx_q == (($past(idx_q) == LAST) ? '0 : $past(idx_q) + 1'b1)));
  // R7
  ctl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl |=> idx_q == '0);
endmodule

// File: tb/smb_host_regs_test.sv
module smb_host_regs_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic xfer_req, xfer_read;
  logic [2:0] xfer_proto;
  logic [6:0] xfer_slave;
  logic [7:0] xfer_cmd, xfer_d0, xfer_d1;
  logic xfer_done = 0;
  logic [7:0] xfer_rx0 = 0, xfer_rx1 = 0;
  logic [4:0] blk_eng_idx = 0;
  logic [7:0] blk_eng_rdata;
  logic blk_eng_we = 0;
  logic [7:0] blk_eng_wdata = 0;

  int checks = 0, failures = 0;
  bit finished = 0;

  int m_busy = 0, m_done = 0, m_err = 0, m_pr = 0;
  int m_ctl = 0, m_cmd = 0, m_adr = 0, m_d0 = 0, m_d1 = 0, m_idx = 0;
  int m_buf [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_host_regs uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) check("R2 req-per-cycle", int'(xfer_req), m_busy);

  function automatic int model_rd(int a);
    case (a)
      0: return m_err*4 + m_done*2 + m_busy;
      2: return m_ctl & 'h1f;
      3: return m_cmd;
      4: return m_adr;
      5: return m_d0;
      6: return m_d1;
      7: return m_buf[m_idx];
      default: return 0;
    endcase
  endfunction

  task automatic bus_write(int a, int d);
    @(negedge clk); bus_wr = 1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(posedge clk); #1; bus_wr = 0;
    case (a)
      0: begin m_done = 0; m_err = 0; m_idx = 0; end
      2: begin
        m_ctl = d;
        if ((d & 'h40) && !m_busy) begin
          int p = (d >> 2) & 7;
          if (p <= 3 || p == 5) begin m_busy = 1; m_pr = p; end else m_err = 1;
        end
      end
      3: m_cmd = d;
      4: m_adr = d;
      5: m_d0 = d;
      6: m_d1 = d;
      7: begin m_buf[m_idx] = d; m_idx = (m_idx + 1) % 32; end
      default: ;
    endcase
  endtask

  task automatic bus_read(string req, int a);
    @(negedge clk); bus_rd = 1; bus_addr = 3'(a); #1;
    check(req, int'(bus_rdata), model_rd(a));
    @(posedge clk); #1; bus_rd = 0;
    if (a == 2) m_idx = 0;
    if (a == 7) m_idx = (m_idx + 1) % 32;
  endtask

  task automatic eng_finish(int r0, int r1);
    @(negedge clk); xfer_done = 1; xfer_rx0 = 8'(r0); xfer_rx1 = 8'(r1);
    @(posedge clk); #1; xfer_done = 0;
    if (m_busy) begin
      m_busy = 0; m_done = 1;
      if (m_adr & 1) begin
        if (m_pr == 1 || m_pr == 2 || m_pr == 5) m_d0 = r0;
        if (m_pr == 3) begin m_d0 = r0; m_d1 = r1; end
      end
    end
  endtask

  task automatic eng_wr(int i, int v);
    @(negedge clk); blk_eng_we = 1; blk_eng_idx = 5'(i); blk_eng_wdata = 8'(v);
    @(posedge clk); #1; blk_eng_we = 0; m_buf[i] = v;
  endtask

  task automatic check_xfer(string req);
    @(negedge clk);
    check(req, int'(xfer_proto), m_pr);
    check(req, int'(xfer_read), m_adr & 1);
    check(req, int'(xfer_slave), m_adr >> 1);
    check(req, int'(xfer_cmd), m_cmd);
    check(req, int'(xfer_d0), m_d0);
    check(req, int'(xfer_d1), m_d1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    foreach (m_buf[i]) m_buf[i] = 0;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    // R10 reset state
    for (int a = 0; a < 7; a++) bus_read("R10 reset", a);
    check("R10 xfer_req", int'(xfer_req), 0);
    // R8 register readback
    bus_write(3, 'h33); bus_write(4, 'hA1); bus_write(5, 'h44); bus_write(6, 'h55);
    bus_write(1, 'hFF);
    for (int a = 1; a < 7; a++) bus_read("R8 readback", a);
    // R1 byte-data read start
    bus_write(2, 'h48);
    check_xfer("R1 fields");
    bus_read("R2 busy", 0);
    // R2 start while busy ignored
    bus_write(2, 'h4C);
    check("R2 proto held", int'(xfer_proto), 2);
    repeat (3) @(posedge clk);
    eng_finish('h5A, 'h77);
    bus_read("R3 byte read d0", 5);
    bus_read("R3 byte read d1", 6);
    bus_read("R2 done", 0);
    bus_write(0, 'h00);
    bus_read("R5 status cleared", 0);
    // R3 word write keeps data
    bus_write(4, 'hA0); bus_write(5, 'h11); bus_write(6, 'h22); bus_write(2, 'h4C);
    check_xfer("R1 word write");
    eng_finish('h99, 'h88);
    bus_read("R3 write keeps d0", 5);
    bus_read("R3 write keeps d1", 6);
    // R3 word read
    bus_write(4, 'hA1); bus_write(2, 'h4C);
    eng_finish('h34, 'h12);
    bus_read("R3 word d0", 5);
    bus_read("R3 word d1", 6);
    // R3 quick command leaves data
    bus_write(2, 'h40);
    check_xfer("R1 quick");
    eng_finish('hEE, 'hDD);
    bus_read("R3 quick d0", 5);
    // R4 bad protocols
    bus_write(0, 0);
    bus_write(2, 'h50);
    bus_read("R4 proto4 err", 0);
    bus_write(0, 0);
    bus_write(2, 'h5C);
    bus_read("R4 proto7 err", 0);
    bus_write(2, 'h58);
    bus_read("R4 proto6 err", 0);
    // R7 control read masks and resets index
    bus_write(2, 'hBC);
    bus_read("R7 ctl mask", 2);
    // R6 block write with wrap
    bus_write(0, 0);
    for (int i = 0; i < 33; i++) bus_write(7, 'h80 + i);
    bus_read("R7 ctl read", 2);
    for (int i = 0; i < 4; i++) bus_read("R6 block read", 7);
    // R9 engine view
    for (int i = 0; i < 32; i += 7) begin
      @(negedge clk); blk_eng_idx = 5'(i); #1;
      check("R9 eng rdata", int'(blk_eng_rdata), m_buf[i]);
    end
    // R9 R3 block read
    bus_write(4, 'hA1); bus_write(2, 'h54);
    check_xfer("R1 block");
    for (int i = 0; i < 4; i++) eng_wr(i, 'hC0 + i);
    eng_finish(4, 0);
    bus_read("R3 block count", 5);
    bus_write(0, 0);
    for (int i = 0; i < 5; i++) bus_read("R9 block data", 7);
    // R5 status write resets index mid-stream
    bus_write(0, 0);
    bus_read("R5 idx reset", 7);
    // R6 full wrap through reads
    for (int i = 0; i < 33; i++) bus_read("R6 wrap read", 7);
    summary();
  end
endmodule